// File: doc/BRIEF.md
# Unlock-Protected Byte Store Controller

This block sits on a simple register bus and fronts a small byte-wide storage array. Software reads a byte by loading an address and setting a request bit in the control register. The byte appears in the data register in the cycle after the request.

Writing a byte is guarded. Software must set the write-enable bit. It must then write the two key values to the key register on consecutive bus cycles, and set the write bit on the very next cycle. Only then does the controller copy the address and the data into its own registers and begin a write that lasts a fixed number of clocks. When the write ends, the write bit drops and a completion flag rises. That flag can raise an interrupt.

The bus is a plain strobe interface with no back-pressure. Every access completes in the cycle it is presented, so the block has no valid/ready handshake. Read data is combinational from the register select while the read strobe is high.

Top module: `nvd_ctrl`

## Requirements
- R1: Writing the control register (select 2) with bit 0 set, while no write is in progress, loads the data register from the array at the current address. The new byte is visible in the following cycle. Control bit 0 reads 1 in that cycle only and then reads 0.
- R2: The data register (select 1) keeps its value across idle cycles and address changes. It changes only when a read loads it or when software writes it.
- R3: A write starts only when three bus writes fall on three consecutive cycles: 55h to the key register (select 3), then AAh to the key register, then a control write with bit 1 set. Control bit 2 (write-enable) must already be 1 when that control write arrives.
- R4: Any other cycle between the steps returns the key tracker to idle. This includes an idle cycle or a read. An AAh with no 55h before it does not arm the tracker. A sequence that fails leaves the array unchanged and leaves control bit 1 at 0.
- R5: Control bit 1 cannot be set while write-enable is 0. Hardware never clears write-enable. Clearing write-enable during a write does not abort that write.
- R6: Once a write starts, control bit 1 reads 1 for exactly WR_CYCLES cycles and then reads 0. The array location written and the value stored are those held in the address and data registers at the start cycle. Later changes to those registers do not affect the write.
- R7: At the end of a write, bit 7 of the flag register (select 4) becomes 1. A software write to select 4 loads that bit from bus bit 7. If a software clear falls in the same cycle as a completion, the completion wins.
- R8: While a write is in progress, read requests and key-register writes are ignored.
- R9: The key register reads back as 0. `irq` is high exactly when the completion flag is 1 and `irq_en` is 1.
- R10: Synchronous reset clears the address, data, control and flag registers and the key tracker. Array contents survive reset.
- R11: The address register is at select 0 and reads back zero-extended. Unused selects read 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Completion interrupt |

## Verification
Two functions can fall in the same cycle. The first pair is the end of a write and a software write to the flag register. The bench starts a write and idles for WR_CYCLES-1 cycles. It then writes 0 to the flag register in exactly the cycle whose clock edge completes the write, and expects the flag to read 1 afterwards. The second pair is a key-register write or a read request arriving on the last busy cycles of a write. The bench expects both to be dropped, and a control write that follows must not start a second write, which it confirms by reading back the array.

// File: rtl/nvd_pkg.sv
package nvd_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_DATA = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_UNLK = 3'd3,
    SEL_FLAG = 3'd4
  } sel_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CTRL_RD   = 0;
  localparam int CTRL_WR   = 1;
  localparam int CTRL_WEN  = 2;
  localparam int FLAG_DONE = 7;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_FIRST = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/nvd_unlock.sv
module nvd_unlock
  import nvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       bus_wr,
  input  logic [2:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       armed
);
  unlock_e st_q, st_d;
  logic    key_wr;

  assign key_wr = bus_wr && (bus_sel == SEL_UNLK) && !busy;

  // Any cycle that is not the expected next step falls back to idle.
  always_comb begin
    st_d = UL_IDLE;
    if (key_wr && bus_wdata == KEY_FIRST)
      st_d = UL_FIRST;
    else if (key_wr && st_q == UL_FIRST && bus_wdata == KEY_SECOND)
      st_d = UL_ARMED;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= UL_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvd_timer.sv
module nvd_timer #(
  parameter int WR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= CW'(WR_CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy = run_q;
  assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/nvd_array.sv
module nvd_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // No reset: contents persist across controller reset.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvd_ctrl.sv
module nvd_ctrl
  import nvd_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int WR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] addr_q, wa_q;
  logic [7:0]    data_q, wd_q, arr_rd, rd_mux;
  logic          wen_q, rd_q, flag_q;
  logic          armed, wr_busy, wr_done;
  logic          wr_ctl, rd_go, start;

  assign wr_ctl = bus_wr && (bus_sel == SEL_CTRL);
  assign rd_go  = wr_ctl && bus_wdata[CTRL_RD] && !wr_busy;
  assign start  = armed && wr_ctl && bus_wdata[CTRL_WR] && wen_q && !wr_busy;

  nvd_unlock u_unlock (
    .clk       (clk),
    .rst       (rst),
    .busy      (wr_busy),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .armed     (armed)
  );

  nvd_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (wr_busy),
    .done  (wr_done)
  );

  nvd_array #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_array (
    .clk   (clk),
    .we    (wr_done),
    .waddr (wa_q),
    .wdata (wd_q),
    .raddr (addr_q),
    .rdata (arr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      wen_q  <= 1'b0;
      rd_q   <= 1'b0;
      flag_q <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      if (bus_wr && bus_sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
      if (rd_go)                              data_q <= arr_rd;
      else if (bus_wr && bus_sel == SEL_DATA) data_q <= bus_wdata;
      if (wr_ctl) wen_q <= bus_wdata[CTRL_WEN];
      rd_q <= rd_go;
      // Completion has priority over a software write of the flag.
      if (wr_done)                            flag_q <= 1'b1;
      else if (bus_wr && bus_sel == SEL_FLAG) flag_q <= bus_wdata[FLAG_DONE];
      if (start) begin
        wa_q <= addr_q;
        wd_q <= data_q;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_sel)
      SEL_ADDR: rd_mux = 8'(addr_q);
      SEL_DATA: rd_mux = data_q;
      SEL_CTRL: rd_mux = {5'b0, wen_q, wr_busy, rd_q};
      SEL_FLAG: rd_mux = {flag_q, 7'b0};
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : 8'h00;
  assign irq       = flag_q && irq_en;
endmodule

// File: rtl/nvd_chk.sv
module nvd_chk
  import nvd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_en,
  input logic       irq,
  input logic       rd_q,
  input logic       wen_q,
  input logic       flag_q,
  input logic       wr_busy,
  input logic       wr_done,
  input logic [7:0] data_q,
  input logic [7:0] arr_rd
);
  assert_rd_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rd_q && !(bus_wr && bus_sel == SEL_CTRL && bus_wdata[CTRL_RD]) |=> !rd_q);

  assert_rd_load_R1: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> data_q == arr_rd);

  assert_start_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(bus_wr && bus_sel == SEL_CTRL && bus_wdata[CTRL_WR]));

  assert_start_wen_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(wen_q));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    wr_busy && !wr_done |=> wr_busy);

  assert_flag_done_R7: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> flag_q && !wr_busy);

  assert_no_rd_busy_R8: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> !rd_q);

  assert_key_zero_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_sel == SEL_UNLK |-> bus_rdata == 8'h00);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> !flag_q && !wr_busy && !rd_q);

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> bus_rdata == 8'h00);
endmodule

bind nvd_ctrl nvd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_en    (irq_en),
  .irq       (irq),
  .rd_q      (rd_q),
  .wen_q     (wen_q),
  .flag_q    (flag_q),
  .wr_busy   (wr_busy),
  .wr_done   (wr_done),
  .data_q    (data_q),
  .arr_rd    (arr_rd)
);

// File: tb/tb_nvd_ctrl.sv
module tb_nvd_ctrl;
  localparam int WR = 12;
  localparam logic [2:0] SA = 3'd0, SD = 3'd1, SC = 3'd2, SU = 3'd3, SF = 3'd4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_en = 1'b0;
  logic       irq;

  int checks = 0, errors = 0;
  logic [7:0] last_rd;

  // behavioural reference state
  int m_addr, m_data, m_wen, m_rd, m_wr, m_cnt, m_flag, m_ust, m_wa, m_wd;
  int m_mem [64];

  always #4 clk = ~clk;

  nvd_ctrl #(.DEPTH(64), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input logic [2:0] s);
    case (s)
      SA: return m_addr;
      SD: return m_data;
      SC: return m_wen * 4 + m_wr * 2 + m_rd;
      SF: return m_flag * 128;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_addr = 0; m_data = 0; m_wen = 0; m_rd = 0; m_wr = 0; m_cnt = 0;
    m_flag = 0; m_ust = 0; m_wa = 0; m_wd = 0;
  endtask

  task automatic model_step(input logic w, input logic [2:0] s, input logic [7:0] d);
    int busy, done, rdgo, start, n_data, nu;
    busy  = m_wr;
    done  = (busy != 0 && m_cnt == 1) ? 1 : 0;
    rdgo  = (w && s == SC && d[0] && busy == 0) ? 1 : 0;
    start = (m_ust == 2 && w && s == SC && d[1] && m_wen != 0 && busy == 0) ? 1 : 0;
    n_data = m_data;
    if (rdgo != 0) n_data = m_mem[m_addr];
    else if (w && s == SD) n_data = int'(d);
    if (start != 0) begin
      m_wa = m_addr; m_wd = m_data; m_cnt = WR; m_wr = 1;
    end else if (busy != 0) begin
      if (done != 0) begin
        m_mem[m_wa] = m_wd; m_wr = 0; m_flag = 1;
      end else m_cnt--;
    end
    if (done == 0 && w && s == SF) m_flag = int'(d[7]);
    nu = 0;
    if (busy == 0 && w && s == SU && d == 8'h55) nu = 1;
    else if (busy == 0 && w && s == SU && m_ust == 1 && d == 8'hAA) nu = 2;
    m_ust = nu;
    if (w && s == SA) m_addr = int'(d) % 64;
    if (w && s == SC) m_wen = int'(d[2]);
    m_rd = rdgo;
    m_data = n_data;
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic bus(input logic w, input logic r, input logic [2:0] s,
                     input logic [7:0] d, input string tag);
    int exp;
    bus_wr = w; bus_rd = r; bus_sel = s; bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    if (r) begin
      exp = model_read(s);
      if (exp >= 0) chk({tag, " model rdata"}, int'(bus_rdata), exp);
    end
    chk({tag, " model irq"}, int'(irq), m_flag & int'(irq_en));
    model_step(w, s, d);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] s, input int exp, input string tag);
    bus(1'b0, 1'b1, s, 8'h00, tag);
    chk(tag, int'(last_rd), exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic write_seq(input logic [7:0] a, input logic [7:0] d, input bit wait_done);
    bus(1, 0, SA, a, "R3");
    bus(1, 0, SD, d, "R3");
    bus(1, 0, SC, 8'h04, "R3");
    bus(1, 0, SU, 8'h55, "R3");
    bus(1, 0, SU, 8'hAA, "R3");
    bus(1, 0, SC, 8'h06, "R3");
    if (wait_done) begin
      for (int i = 0; i < WR; i++) expect_rd(SC, 8'h06, "R6 busy");
      expect_rd(SC, 8'h04, "R6 done");
      bus(1, 0, SF, 8'h00, "R7");
    end
  endtask

  task automatic do_read(input logic [7:0] a, input int exp, input string tag);
    bus(1, 0, SA, a, tag);
    bus(1, 0, SC, 8'h01, tag);
    expect_rd(SD, exp, {tag, " data"});
    expect_rd(SC, 8'h00, "R1 rd clear");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = -1;
    model_reset();
    @(negedge clk);
    do_reset();

    for (int s = 0; s < 5; s++) expect_rd(3'(s), 0, "R10 reset");
    expect_rd(3'd6, 0, "R11 unused");
    bus(1, 0, SA, 8'hFF, "R11");
    expect_rd(SA, 8'h3F, "R11 addr width");
    bus(0, 0, SA, 8'h00, "R11");
    chk("R11 rd low", int'(last_rd), 0);

    write_seq(8'd5, 8'h3C, 1'b0);
    for (int i = 0; i < WR; i++) expect_rd(SC, 8'h06, "R6 busy");
    expect_rd(SC, 8'h04, "R6 done");
    expect_rd(SF, 8'h80, "R7 flag");
    irq_en = 1'b1;
    bus(0, 0, SA, 8'h00, "R9");
    chk("R9 irq on", int'(irq), 1);
    irq_en = 1'b0;
    bus(0, 0, SA, 8'h00, "R9");
    chk("R9 irq off", int'(irq), 0);
    bus(1, 0, SU, 8'h55, "R9");
    expect_rd(SU, 0, "R9 key reads zero");
    bus(1, 0, SF, 8'h00, "R7");
    expect_rd(SF, 0, "R7 sw clear");

    do_read(8'd5, 8'h3C, "R1");
    bus(1, 0, SD, 8'h77, "R2");
    repeat (3) bus(0, 0, SA, 8'h00, "R2");
    bus(1, 0, SA, 8'd9, "R2");
    expect_rd(SD, 8'h77, "R2 hold");

    write_seq(8'd9, 8'h11, 1'b1);
    write_seq(8'd13, 8'hC3, 1'b1);
    bus(1, 0, SA, 8'd9, "R4");
    bus(1, 0, SD, 8'h99, "R4");
    bus(1, 0, SC, 8'h04, "R4");
    bus(1, 0, SU, 8'h55, "R4"); bus(0, 0, SA, 0, "R4");
    bus(1, 0, SU, 8'hAA, "R4"); bus(1, 0, SC, 8'h06, "R4");
    expect_rd(SC, 8'h04, "R4 gap");
    bus(1, 0, SU, 8'hAA, "R4"); bus(1, 0, SC, 8'h06, "R4");
    expect_rd(SC, 8'h04, "R4 lone AA");
    bus(1, 0, SU, 8'h55, "R4"); bus(1, 0, SU, 8'hAA, "R4");
    bus(0, 1, SA, 0, "R4"); bus(1, 0, SC, 8'h06, "R4");
    expect_rd(SC, 8'h04, "R4 read between");
    do_read(8'd9, 8'h11, "R4 unchanged");

    bus(1, 0, SD, 8'h99, "R5");
    bus(1, 0, SU, 8'h55, "R5"); bus(1, 0, SU, 8'hAA, "R5");
    bus(1, 0, SC, 8'h02, "R5");
    expect_rd(SC, 8'h00, "R5 no wen");
    do_read(8'd9, 8'h11, "R5 unchanged");

    write_seq(8'd12, 8'h5A, 1'b0);
    bus(1, 0, SC, 8'h00, "R5");
    bus(1, 0, SC, 8'h01, "R8");
    expect_rd(SC, 8'h02, "R8 rd ignored");
    bus(1, 0, SA, 8'd13, "R6");
    bus(1, 0, SD, 8'h00, "R6");
    bus(1, 0, SC, 8'h04, "R8");
    for (int i = 0; i < WR - 8; i++) bus(0, 0, SA, 8'd13, "R8");
    bus(1, 0, SU, 8'h55, "R8");
    bus(1, 0, SU, 8'hAA, "R8");
    bus(1, 0, SC, 8'h06, "R8");
    expect_rd(SC, 8'h04, "R5 wen kept");
    expect_rd(SF, 8'h80, "R5 write finished");
    bus(1, 0, SF, 8'h00, "R7");
    do_read(8'd12, 8'h5A, "R6 snapshot");
    do_read(8'd13, 8'hC3, "R8 key ignored");

    write_seq(8'd20, 8'h42, 1'b0);
    for (int i = 0; i < WR - 1; i++) bus(0, 0, SA, 8'd20, "R7");
    bus(1, 0, SF, 8'h00, "R7");
    expect_rd(SF, 8'h80, "R7 completion wins");
    bus(1, 0, SF, 8'h00, "R7");
    expect_rd(SF, 8'h00, "R7 cleared");

    bus(1, 0, SA, 8'd20, "R10");
    bus(1, 0, SC, 8'h04, "R10");
    do_reset();
    expect_rd(SA, 0, "R10 addr");
    expect_rd(SC, 0, "R10 ctrl");
    do_read(8'd20, 8'h42, "R10 array kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule